// File: doc/BRIEF.md
# Byte-Stream Command Port

This block is the device side of a two-location, byte-wide register window through which a host talks to a small coprocessor. Offset 0 is a data port. Offset 1 reads back a status byte and takes command codes when written. The host opens a request with a mode command. It then streams request bytes into the data port, pacing itself on the input-buffer-full flag, and closes the request with an end command. The block answers with a framed response that the host drains one byte at a time from the data port, pacing itself on the output-buffer-full flag.

Behind the port sits an echo responder. The response payload is the request itself, except that bytes 2 to 5 are overwritten with the payload length as a big-endian 32-bit number. A payload is never shorter than six bytes, and missing request bytes read as zero. The frame starts and ends with a marker byte that is shown together with a separate frame flag. A cancel command written at any time returns the port to idle in one cycle.

The host side is a plain register bus with single-cycle read and write strobes. Back-pressure runs through the status flags. The host must not write while input-buffer-full is set, and the block drops such writes. The host takes a response byte only while output-buffer-full is set. The read data is combinational on the address.

Top module: `cmd_byte_port`

## Requirements
- R1: After reset the status byte reads 0x10. Its bits are: 0 output-full, 1 input-full, 2 frame flag, 3 command-held, 4 ready-for-command, 5 ready-for-data, 7 overflow, and bit 6 is always 0. Offset 0 is the data port and offset 1 is status on read and command on write.
- R2: Writing 0x22 to offset 1 in any state makes the status read exactly 0x10 in the next cycle and abandons any request or response in progress.
- R3: A write to either offset while input-full is clear sets input-full from the next cycle. The byte is consumed one cycle later and input-full clears the cycle after that. Command-held (bit 3) is set while the held byte was written to offset 1.
- R4: Command 0x01, consumed while idle or receiving, empties the request buffer and enters receive mode: ready-for-data set and ready-for-command clear.
- R5: In receive mode, data-port bytes are stored in order, up to 64 bytes. Further bytes are dropped and set the overflow bit, which stays set until the next 0x01 or 0x22.
- R6: Command 0x03, consumed in receive mode, starts a response. The first byte shown is 0x01 with output-full and the frame flag both set.
- R7: Payload bytes follow with output-full set and the frame flag clear. With N stored bytes the payload length is L = max(N, 6). Bytes 2..5 hold L big-endian. The other bytes echo the request, or read 0 where the request is shorter.
- R8: After the payload the block shows 0x03 with output-full and the frame flag set. Reading it returns the port to idle, with ready-for-command set and the overflow bit kept.
- R9: A data-port read while output-full is set clears output-full in the next cycle, and the next frame byte appears one cycle after that.
- R10: Bytes that do not fit the current mode are consumed with no effect. These are a data byte or 0x03 while idle, and 0x01 while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = data port, 1 = status/command |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; on offset 0 it takes the shown byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Status byte (offset 1) or shown response byte (offset 0) |

## Verification
The bench checks request lengths that matter most: empty and short requests, where zero padding and a forced length of 6 apply, a request of exactly 64 bytes, and one that spills past 64. A design that mishandled these would emit the wrong length field, leak stale buffer bytes or miss the overflow bit. Cancel is issued both in idle and in the middle of a response, because a design that let any flag survive would not read exactly 0x10. Misplaced bytes are also injected: a data byte or end command while idle, and a mode command during a response. A design that acted on them would change mode or corrupt the frame. The gap of one empty cycle between a read and the next byte is sampled on every byte, so both a late reload and a stuck output-full are exposed.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_OPEN  = 8'h01;
  localparam logic [BYTE_W-1:0] CODE_CLOSE = 8'h03;
  localparam logic [BYTE_W-1:0] CODE_ABORT = 8'h22;
  localparam logic [BYTE_W-1:0] IDLE_STATUS = 8'h10;

  localparam int MIN_PAYLOAD = 6;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RECV = 2'd1,
    MODE_RESP = 2'd2
  } mode_e;
endpackage

// File: rtl/cp_in_stage.sv
module cp_in_stage
  import cmdport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic              wr_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              full,
  output logic              from_cmd,
  output logic              take,
  output logic [BYTE_W-1:0] held
);
  logic vld_q, done_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q    <= 1'b0;
      done_q   <= 1'b0;
      from_cmd <= 1'b0;
      held     <= '0;
    end else if (done_q) begin
      vld_q    <= 1'b0;
      done_q   <= 1'b0;
      from_cmd <= 1'b0;
    end else if (vld_q) begin
      done_q <= 1'b1;
    end else if (wr_en) begin
      vld_q    <= 1'b1;
      from_cmd <= wr_cmd;
      held     <= wr_data;
    end
  end

  assign full = vld_q;
  assign take = vld_q && !done_q;

  // R3: input-full stays up for the consume cycle, then drops
  p_ibf_two_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n || flush)
    $rose(full) |=> full ##1 !full);
endmodule

// File: rtl/cp_req_store.sv
module cp_req_store
  import cmdport_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CW-1:0]     count,
  output logic              ovf
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic room;

  assign room = (count < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (room) count <= count + CW'(1);
      else      ovf   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && room) mem[count[IW-1:0]] <= push_data;
  end

  assign rd_data = mem[rd_idx];

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clear) |=> ovf);
endmodule

// File: rtl/cp_resp_framer.sv
module cp_resp_framer
  import cmdport_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH + 4)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start,
  input  logic              host_take,
  input  logic [CW-1:0]     count,
  input  logic [BYTE_W-1:0] pay_byte,
  output logic [IW-1:0]     pay_idx,
  output logic              obf,
  output logic              f0,
  output logic [BYTE_W-1:0] out_byte,
  output logic              finish
);
  logic          active;
  logic [PW-1:0] pos, idx, len_p;
  logic [31:0]   len32;
  logic [BYTE_W-1:0] nxt;
  logic          is_marker;

  always_comb begin
    len_p = (count < CW'(MIN_PAYLOAD)) ? PW'(MIN_PAYLOAD) : PW'(count);
    len32 = 32'(len_p);
    idx   = pos - PW'(1);
  end
  assign pay_idx   = idx[IW-1:0];
  assign is_marker = (pos == '0) || (pos == len_p + PW'(1));

  always_comb begin
    if (pos == '0)                        nxt = CODE_OPEN;
    else if (pos == len_p + PW'(1))       nxt = CODE_CLOSE;
    else if (idx >= PW'(2) && idx <= PW'(5)) begin
      case (idx)
        PW'(2):  nxt = len32[31:24];
        PW'(3):  nxt = len32[23:16];
        PW'(4):  nxt = len32[15:8];
        default: nxt = len32[7:0];
      endcase
    end else if (idx < PW'(count))        nxt = pay_byte;
    else                                  nxt = '0;
  end

  assign finish = active && obf && host_take && (pos == len_p + PW'(2));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      active   <= 1'b0;
      pos      <= '0;
      obf      <= 1'b0;
      f0       <= 1'b0;
      out_byte <= '0;
    end else if (start) begin
      active <= 1'b1;
      pos    <= '0;
      obf    <= 1'b0;
      f0     <= 1'b0;
    end else if (active) begin
      if (obf && host_take) begin
        obf <= 1'b0;
        f0  <= 1'b0;
        if (finish) active <= 1'b0;
      end else if (!obf && pos <= len_p + PW'(1)) begin
        obf      <= 1'b1;
        f0       <= is_marker;
        out_byte <= nxt;
        pos      <= pos + PW'(1);
      end
    end
  end

  // R6/R8: frame flag only appears with a byte on show
  p_f0_with_obf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    f0 |-> obf);
  // R9: one empty cycle between a taken byte and the next one
  p_reload_gap_r9: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (obf && host_take && !finish) |=> !obf ##1 obf);
endmodule

// File: rtl/cmd_byte_port.sv
module cmd_byte_port
  import cmdport_pkg::*;
#(
  parameter int DEPTH = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  mode_e mode_q;
  logic cancel_hit, in_wr, host_take;
  logic ibf, from_cmd, take;
  logic [BYTE_W-1:0] held;
  logic cmd_open, cmd_close, data_push;
  logic [IW-1:0] pay_idx;
  logic [BYTE_W-1:0] pay_byte, out_byte;
  logic [CW-1:0] count;
  logic ovf, obf, f0, finish;
  logic rdy, ibr;
  logic [BYTE_W-1:0] status;

  assign cancel_hit = bus_wr && bus_addr && (bus_wdata == CODE_ABORT);
  assign in_wr      = bus_wr && !cancel_hit && !ibf;
  assign host_take  = bus_rd && !bus_addr && (mode_q == MODE_RESP);

  cp_in_stage u_in (
    .clk(clk), .rst_n(rst_n), .flush(cancel_hit),
    .wr_en(in_wr), .wr_cmd(bus_addr), .wr_data(bus_wdata),
    .full(ibf), .from_cmd(from_cmd), .take(take), .held(held)
  );

  assign cmd_open  = take && from_cmd && (held == CODE_OPEN) && (mode_q != MODE_RESP);
  assign cmd_close = take && from_cmd && (held == CODE_CLOSE) && (mode_q == MODE_RECV);
  assign data_push = take && !from_cmd && (mode_q == MODE_RECV);

  cp_req_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(cancel_hit || cmd_open),
    .push(data_push), .push_data(held),
    .rd_idx(pay_idx), .rd_data(pay_byte), .count(count), .ovf(ovf)
  );

  cp_resp_framer #(.DEPTH(DEPTH)) u_frame (
    .clk(clk), .rst_n(rst_n), .flush(cancel_hit), .start(cmd_close),
    .host_take(host_take), .count(count), .pay_byte(pay_byte),
    .pay_idx(pay_idx), .obf(obf), .f0(f0), .out_byte(out_byte), .finish(finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || cancel_hit)  mode_q <= MODE_IDLE;
    else if (cmd_open)         mode_q <= MODE_RECV;
    else if (cmd_close)        mode_q <= MODE_RESP;
    else if (finish)           mode_q <= MODE_IDLE;
  end

  assign rdy = (mode_q == MODE_IDLE);
  assign ibr = (mode_q == MODE_RECV);
  assign status = {ovf, 1'b0, ibr, rdy, from_cmd && ibf, f0, ibf, obf};
  assign bus_rdata = bus_addr ? status : out_byte;

  // R2: cancel leaves exactly ready-for-command
  p_abort_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_hit |=> (status == IDLE_STATUS));
  // R4/R8: ready-for-command, ready-for-data and output-full are exclusive
  p_mode_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rdy, ibr, obf}));
  // R10: a held byte never changes mode during a response except via finish
  p_resp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || cancel_hit)
    (mode_q == MODE_RESP && !finish) |=> (mode_q == MODE_RESP));
endmodule

// File: tb/tb_cmd_byte_port.sv
module tb_cmd_byte_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] req [0:127];

  cmd_byte_port #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all tasks are entered just after a falling edge
  task automatic peek(input bit a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic host_wr(input bit a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic host_rd(output logic [7:0] v);
    peek(1'b0, v);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_bit(input int b, input bit val);
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      peek(1'b1, s);
      if (s[b] == val) return;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int n, input int idx);
    int st, len;
    st = (n > DEPTH) ? DEPTH : n;
    len = (st < 6) ? 6 : st;
    if (idx >= 2 && idx <= 5) return 8'((len >> (8 * (5 - idx))) & 255);
    if (idx < st) return req[idx];
    return 8'h00;
  endfunction

  task automatic run_frame(input int n, input bit do_cancel, input bit first,
                           input bit poke_open, input bit abort_mid);
    logic [7:0] s, d, ov;
    int st, len;
    st = (n > DEPTH) ? DEPTH : n;
    len = (st < 6) ? 6 : st;
    ov = (n > DEPTH) ? 8'h80 : 8'h00;
    if (do_cancel) begin
      host_wr(1'b1, 8'h22);
      peek(1'b1, s);
      chk(s == 8'h10, "R2 cancel status", s, 8'h10);
    end
    wait_bit(1, 1'b0);
    host_wr(1'b1, 8'h01);
    if (first) begin
      peek(1'b1, s); chk(s == 8'h1A, "R3 held command", s, 8'h1A);
      @(negedge clk);
      peek(1'b1, s); chk(s == 8'h2A, "R4 consumed open", s, 8'h2A);
      @(negedge clk);
      peek(1'b1, s); chk(s == 8'h20, "R3 input-full cleared", s, 8'h20);
    end
    for (int i = 0; i < n; i++) begin
      wait_bit(1, 1'b0);
      host_wr(1'b0, req[i]);
    end
    wait_bit(1, 1'b0);
    host_wr(1'b1, 8'h03);
    wait_bit(0, 1'b1);
    peek(1'b1, s);
    chk(s == (8'h05 | ov), "R6 open frame status", s, 8'h05 | ov);
    chk(s[7] == ov[7], "R5 overflow bit", s[7], ov[7]);
    if (poke_open) begin
      host_wr(1'b1, 8'h01);
      repeat (3) @(negedge clk);
      peek(1'b1, s);
      chk(s == (8'h05 | ov), "R10 open during response", s, 8'h05 | ov);
    end
    host_rd(d);
    chk(d == 8'h01, "R6 open marker", d, 8'h01);
    for (int j = 0; j < len; j++) begin
      peek(1'b1, s);
      chk(s[0] == 1'b0, "R9 output-full after read", s[0], 0);
      @(negedge clk);
      peek(1'b1, s);
      chk(s == (8'h01 | ov), "R7 payload status", s, 8'h01 | ov);
      host_rd(d);
      chk(d == exp_byte(n, j), $sformatf("R7 payload byte %0d len %0d", j, n), d, exp_byte(n, j));
      if (abort_mid && j == 2) begin
        host_wr(1'b1, 8'h22);
        peek(1'b1, s);
        chk(s == 8'h10, "R2 cancel mid response", s, 8'h10);
        return;
      end
    end
    @(negedge clk);
    peek(1'b1, s);
    chk(s == (8'h05 | ov), "R8 close status", s, 8'h05 | ov);
    host_rd(d);
    chk(d == 8'h03, "R8 close marker", d, 8'h03);
    peek(1'b1, s);
    chk(s == (8'h10 | ov), "R8 back to idle", s, 8'h10 | ov);
  endtask

  initial begin
    logic [7:0] s;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) req[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(1'b1, s);
    chk(s == 8'h10, "R1 reset status", s, 8'h10);

    // R10: stray bytes while idle
    host_wr(1'b0, 8'h55);
    repeat (3) @(negedge clk);
    peek(1'b1, s); chk(s == 8'h10, "R10 data while idle", s, 8'h10);
    host_wr(1'b1, 8'h03);
    repeat (3) @(negedge clk);
    peek(1'b1, s); chk(s == 8'h10, "R10 close while idle", s, 8'h10);

    run_frame(0, 1'b0, 1'b1, 1'b0, 1'b0);   // empty request, no cancel first
    run_frame(3, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame(6, 1'b1, 1'b0, 1'b1, 1'b0);
    run_frame(64, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame(70, 1'b1, 1'b0, 1'b0, 1'b0);  // overflow, R5
    run_frame(12, 1'b1, 1'b0, 1'b0, 1'b1);  // cancel mid response
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 128; i++) req[i] = 8'($urandom);
      run_frame(int'($urandom_range(0, 72)), 1'b1, 1'b0, 1'b0, 1'b0);
    end
    host_wr(1'b1, 8'h22);
    peek(1'b1, s);
    chk(s == 8'h10, "R5 overflow cleared by cancel", s, 8'h10);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule